// File: doc/BRIEF.md
# Five-Level Single-Carrier Phase-Disposed PWM Modulator

This block drives the eight gate signals of each leg of a five-level diode-clamped inverter. It supports up to three legs that share one time base. The four stacked triangular carriers of phase-disposed sinusoidal PWM are replaced by one up/down counter. The reference is moved into the carrier band it falls in, instead of moving the carrier to the reference. At each carrier turnaround, every leg does three things:
- takes a new signed reference sample;
- finds which of the four bands holds the sample;
- turns the position of the sample inside that band into a compare count scaled by the period.

The leg's output level is the band index plus the result of comparing that count with the carrier. The level selects four adjacent conducting switches. Each complementary switch pair passes through its own dead-time stage.

Software or a sine generator supplies the period count, one reference word per leg, and a dead-time count in clock cycles. The gate bits go straight to the gate-driver stage.

Top module: `pdpwm_5l`

## Requirements
- R1: The carrier counts up from 0 to `period` and back down, one step per clock, so one carrier period lasts 2·`period` cycles. With `period` = 0 the carrier holds at 0.
- R2: A leg samples its reference, band and compare count only in a turnaround cycle, which is the count at `period` while rising or at 0 while falling. A reference change between turnarounds has no effect on the gates until the next turnaround.
- R3: Each reference is a two's-complement word with `FRAC_W` fractional bits, in units of one carrier band. Values above 2 − 2^−FRAC_W or below −2 are saturated to those limits.
- R4: The bands are b1 = [−2,−1), b2 = [−1,0), b3 = [0,1) and b4 = [1,2). The compare count is floor(`period` · v), where v is the reference minus the lower edge of its band. A reference exactly on a band edge belongs to the upper band, with v = 0.
- R5: The output level is the band index minus one (0 to 3), plus one while the compare count is above the carrier. For leg l, bit l·8+n−1 of `gates` drives switch S(n). Level 4 closes S1–S4, level 3 closes S2–S5, level 2 closes S3–S6, level 1 closes S4–S7 and level 0 closes S5–S8.
- R6: The pairs are (S1,S5), (S2,S6), (S3,S7) and (S4,S8). While a band is held, only the pair of that band switches: b4 uses the first pair and b1 uses the fourth. The other pairs stay fixed.
- R7: After any change of a pair's commanded state, both switches of that pair stay off for `dead_cnt` cycles. The two switches of a pair are never on together. With `dead_cnt` = 0 there is no gap.
- R8: In steady state with 0 < C < `period`, over one carrier period the upper switch of the active pair is on for 2C − 1 − `dead_cnt` cycles. The lower switch is on for 2·`period` − 2C + 1 − `dead_cnt` cycles.
- R9: During reset every gate is off. After reset, each leg turns on the zero level (S3–S6) once `dead_cnt` cycles have passed.
- R10: All legs share the one carrier, and each leg keeps its own band and compare count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period | input | CNT_W | Carrier half-period count |
| dead_cnt | input | DT_W | Dead time in clock cycles |
| ref_in | input | NUM_LEGS·(FRAC_W+3) | Per-leg signed reference words, leg 0 in the low bits |
| gates | output | NUM_LEGS·8 | Gate commands, 8 per leg, S1 at the lowest bit of each leg |

## Verification
The bench builds the block with an 8-bit carrier, 6 fractional reference bits, a 4-bit dead-time count and three legs.

With carrier periods of 7 and 20 counts, whole carrier periods fit in a few dozen cycles. This lets the bench compare exact on-time counts per pair against the dead-time-corrected duty formula. The narrow 9-bit reference word can carry ±3, so both saturation limits can be reached.

The three legs are placed in three different bands at once, which shows that each leg keeps its own band on the shared carrier. Further runs cover the band edges, a zero period, a reference change in mid-period, and a zero dead time.

// File: rtl/pdpwm_pkg.sv
// Package: shared types of the five-level modulator.
// Assumes: the band index is encoded so that the level arithmetic can use it directly (b1 = 0 .. b4 = 3).
package pdpwm_pkg;

    typedef enum logic [1:0] {
        BAND_1 = 2'd0,
        BAND_2 = 2'd1,
        BAND_3 = 2'd2,
        BAND_4 = 2'd3
    } band_e;

    localparam int PAIRS_PER_LEG = 4;
    localparam int GATES_PER_LEG = 8;

endpackage

// File: rtl/pdpwm_carrier.sv
// Module: shared triangular carrier built from one up/down counter.
// Assumes: period may change at any time; a count above a new, smaller period
// simply turns and counts down. turn marks the cycle in which legs resample.
module pdpwm_carrier #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             turn
);

    logic rising;

    // Turnaround: top while rising, bottom while falling, or a degenerate zero period.
    assign turn = (period == '0) || (rising && (cnt >= period)) || (!rising && (cnt == '0));

    // Count step and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (period == '0) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (cnt >= period) begin
                rising <= 1'b0;
                cnt    <= cnt - 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                rising <= 1'b1;
                cnt    <= cnt + 1'b1;
            end else begin
                cnt    <= cnt - 1'b1;
            end
        end
    end

    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(period) != '0) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == CNT_W'($past(cnt) - 1'b1)))); // R1

endmodule

// File: rtl/pdpwm_band.sv
// Module: per-leg band selection, reference rebasing and level decode.
// Assumes: ref_in is signed with FRAC_W fractional bits in band units. The band
// and compare count are reloaded only when turn is high.
module pdpwm_band
    import pdpwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        period,
    input  logic [CNT_W-1:0]        cnt,
    input  logic                    turn,
    input  logic signed [FRAC_W+2:0] ref_in,
    output logic [PAIRS_PER_LEG-1:0] want_hi
);

    localparam int RW = FRAC_W + 3;
    localparam int CW = FRAC_W + 2;
    localparam int PW = CNT_W + FRAC_W;
    localparam logic signed [RW-1:0] HI_LIM = RW'((2 ** (FRAC_W + 1)) - 1);
    localparam logic signed [RW-1:0] LO_LIM = -HI_LIM - RW'(1);

    logic signed [CW-1:0] clip;
    logic [FRAC_W-1:0]    frac;
    logic [PW-1:0]        prod;
    logic [CNT_W-1:0]     cmp_new;
    band_e                band_new;
    band_e                band_q;
    logic [CNT_W-1:0]     cmp_q;
    logic [2:0]           level;

    // Saturate the reference to the four-band span.
    always_comb begin
        if (ref_in > HI_LIM)      clip = {1'b0, {(CW-1){1'b1}}};
        else if (ref_in < LO_LIM) clip = {1'b1, {(CW-1){1'b0}}};
        else                      clip = ref_in[CW-1:0];
    end

    // Band from the integer part, position inside the band from the fraction.
    always_comb begin
        band_new = band_e'({~clip[CW-1], clip[CW-2]});
        frac     = clip[FRAC_W-1:0];
        prod     = {{FRAC_W{1'b0}}, period} * {{CNT_W{1'b0}}, frac};
        cmp_new  = prod[PW-1:FRAC_W];
    end

    // Hold band and compare count between carrier turnarounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q <= BAND_3;
            cmp_q  <= '0;
        end else if (turn) begin
            band_q <= band_new;
            cmp_q  <= cmp_new;
        end
    end

    // Level and the per-pair upper-switch command.
    always_comb begin
        level = {1'b0, band_q} + {2'b00, (cmp_q > cnt)};
        for (int j = 0; j < PAIRS_PER_LEG; j++) begin
            want_hi[j] = (level >= 3'(PAIRS_PER_LEG - j));
        end
    end

    AST_HOLD_BETWEEN_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(turn)) |-> ($stable(cmp_q) && $stable(band_q))); // R2

    AST_CMP_INSIDE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(turn) && $past(period) != '0) |-> (cmp_q < $past(period))); // R4

endmodule

// File: rtl/pdpwm_deadband.sv
// Module: dead-time stage for one complementary switch pair.
// Assumes: dead is sampled when the commanded state flips. Reset holds both
// switches off for dead cycles and then settles to the RST_HI state.
module pdpwm_deadband #(
    parameter int DT_W   = 8,
    parameter bit RST_HI = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dead,
    input  logic            want_hi,
    output logic            gate_hi,
    output logic            gate_lo
);

    logic            cur;
    logic [DT_W-1:0] dt;

    // Track the commanded state and run the blanking counter after each flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= RST_HI;
            dt  <= dead;
        end else if (want_hi != cur) begin
            cur <= want_hi;
            dt  <= dead;
        end else if (dt != '0) begin
            dt <= dt - 1'b1;
        end
    end

    // Drive a switch only once blanking is over.
    assign gate_hi = cur && (dt == '0);
    assign gate_lo = !cur && (dt == '0);

    AST_GAP_BEFORE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) && dead != '0) |-> !$past(gate_lo)); // R7

    AST_GAP_BEFORE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && dead != '0) |-> !$past(gate_hi)); // R7

endmodule

// File: rtl/pdpwm_5l.sv
// Module: top of the five-level single-carrier PWM modulator.
// Assumes: all legs share one carrier. Leg l uses ref_in[l*(FRAC_W+3) +: FRAC_W+3]
// and gates[l*8 +: 8], with bit n-1 driving S(n).
module pdpwm_5l
    import pdpwm_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int FRAC_W   = 10,
    parameter int DT_W     = 8,
    parameter int NUM_LEGS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CNT_W-1:0]                period,
    input  logic [DT_W-1:0]                 dead_cnt,
    input  logic [NUM_LEGS*(FRAC_W+3)-1:0]  ref_in,
    output logic [NUM_LEGS*8-1:0]           gates
);

    localparam int RW = FRAC_W + 3;

    logic [CNT_W-1:0] cnt;
    logic             turn;

    pdpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .cnt    (cnt),
        .turn   (turn)
    );

    for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
        logic [PAIRS_PER_LEG-1:0] want_hi;
        logic [GATES_PER_LEG-1:0] leg_gates;

        pdpwm_band #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_band (
            .clk     (clk),
            .rst_n   (rst_n),
            .period  (period),
            .cnt     (cnt),
            .turn    (turn),
            .ref_in  (ref_in[l*RW +: RW]),
            .want_hi (want_hi)
        );

        for (genvar j = 0; j < PAIRS_PER_LEG; j++) begin : g_pair
            pdpwm_deadband #(.DT_W(DT_W), .RST_HI(j >= 2)) u_db (
                .clk     (clk),
                .rst_n   (rst_n),
                .dead    (dead_cnt),
                .want_hi (want_hi[j]),
                .gate_hi (leg_gates[j]),
                .gate_lo (leg_gates[j + PAIRS_PER_LEG])
            );
        end

        assign gates[l*GATES_PER_LEG +: GATES_PER_LEG] = leg_gates;

        AST_LEVEL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(leg_gates) == 4) |-> (leg_gates == 8'h0F || leg_gates == 8'h1E ||
            leg_gates == 8'h3C || leg_gates == 8'h78 || leg_gates == 8'hF0)); // R5

        AST_AT_MOST_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(leg_gates) <= 4); // R5
    end

endmodule

// File: tb/tb_pdpwm_5l.sv
module tb_pdpwm_5l;

    localparam int CW = 8;
    localparam int FW = 6;
    localparam int DW = 4;
    localparam int NL = 3;
    localparam int RW = FW + 3;
    localparam int ONE = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CW-1:0]     period;
    logic [DW-1:0]     dead_cnt;
    logic [NL*RW-1:0]  ref_in;
    logic [NL*8-1:0]   gates;

    int checks = 0;
    int failures = 0;
    int overlaps = 0;
    int cyc = 0;
    bit done = 0;
    int hi_c [NL][4];
    int lo_c [NL][4];

    always #10 clk = ~clk;

    pdpwm_5l #(.CNT_W(CW), .FRAC_W(FW), .DT_W(DW), .NUM_LEGS(NL)) dut (
        .clk (clk), .rst_n (rst_n), .period (period),
        .dead_cnt (dead_cnt), .ref_in (ref_in), .gates (gates)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // R7: the two switches of a pair are never on together
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < NL; l++)
                for (int j = 0; j < 4; j++)
                    if (gates[l*8+j] && gates[l*8+j+4]) overlaps++;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_ref(int l, int v);
        ref_in[l*RW +: RW] = RW'(v);
    endtask

    task automatic settle(int p);
        repeat (8*p + 24) @(negedge clk);
    endtask

    task automatic window(int n);
        for (int l = 0; l < NL; l++)
            for (int j = 0; j < 4; j++) begin
                hi_c[l][j] = 0;
                lo_c[l][j] = 0;
            end
        repeat (n) begin
            @(negedge clk);
            for (int l = 0; l < NL; l++)
                for (int j = 0; j < 4; j++) begin
                    if (gates[l*8+j])   hi_c[l][j]++;
                    if (gates[l*8+j+4]) lo_c[l][j]++;
                end
        end
    endtask

    // Expected on-times derived from R3, R4, R6 and R8
    task automatic check_leg(int l, int raw, int p, int d, int win, string tag);
        int clip, band, frac, cmp, act, ehi, elo;
        clip = raw > 2*ONE-1 ? 2*ONE-1 : (raw < -2*ONE ? -2*ONE : raw);
        band = (clip >>> FW) + 2;
        frac = clip - (band - 2) * ONE;
        cmp  = (p * frac) / ONE;
        act  = 4 - band;
        for (int j = 0; j < 4; j++) begin
            if (j + 1 > act)      begin ehi = win; elo = 0;   end
            else if (j + 1 < act) begin ehi = 0;   elo = win; end
            else if (cmp == 0)    begin ehi = 0;   elo = win; end
            else begin
                ehi = 2*cmp - 1 - d;          if (ehi < 0) ehi = 0;
                elo = 2*p - 2*cmp + 1 - d;    if (elo < 0) elo = 0;
            end
            check(hi_c[l][j] == ehi, $sformatf("%s leg%0d upper S%0d", tag, l, j+1), hi_c[l][j], ehi);
            check(lo_c[l][j] == elo, $sformatf("%s leg%0d lower S%0d", tag, l, j+5), lo_c[l][j], elo);
        end
    endtask

    task automatic t_reset();
        check(gates == '0, "R9 gates off in reset", int'(gates), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gates == '0, "R9 blanking after reset", int'(gates), 0);
        repeat (4) @(negedge clk);
        for (int l = 0; l < NL; l++)
            check(gates[l*8 +: 8] == 8'h3C, $sformatf("R5 R9 zero level leg%0d", l), int'(gates[l*8 +: 8]), 8'h3C);
    endtask

    task automatic t_three_bands();
        period = 8'd20; dead_cnt = 4'd3;
        set_ref(0, 96); set_ref(1, -16); set_ref(2, -112);
        settle(20); window(40);
        check_leg(0,  96, 20, 3, 40, "R4 R6 R8 R10");
        check_leg(1, -16, 20, 3, 40, "R4 R6 R8 R10");
        check_leg(2, -112, 20, 3, 40, "R4 R6 R8 R10");
    endtask

    task automatic t_edges();
        set_ref(0, 32); set_ref(1, 0); set_ref(2, -64);
        settle(20); window(40);
        check_leg(0,  32, 20, 3, 40, "R4 R8 band b3");
        check_leg(1,   0, 20, 3, 40, "R4 edge at 0");
        check_leg(2, -64, 20, 3, 40, "R4 edge at -1");
    endtask

    task automatic t_saturate();
        set_ref(0, 192); set_ref(1, -192); set_ref(2, 64);
        settle(20); window(40);
        check_leg(0,  192, 20, 3, 40, "R3 upper clamp");
        check_leg(1, -192, 20, 3, 40, "R3 lower clamp");
        check_leg(2,   64, 20, 3, 40, "R4 edge at +1");
    endtask

    task automatic t_period();
        period = 8'd7;
        set_ref(0, 32); set_ref(1, 32); set_ref(2, -32);
        settle(7); window(14);
        check_leg(0,  32, 7, 3, 14, "R1 short period");
        check_leg(2, -32, 7, 3, 14, "R1 short period");
        period = 8'd0;
        set_ref(0, 96);
        settle(4); window(16);
        check_leg(0, 96, 0, 3, 16, "R1 zero period");
    endtask

    task automatic t_deferred();
        period = 8'd20;
        set_ref(0, 32); set_ref(1, 0); set_ref(2, 0);
        settle(20);
        while (gates[1] == 1'b0) @(negedge clk);
        while (gates[1] == 1'b1) @(negedge clk);
        set_ref(0, 64);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(gates[1] == 1'b0, "R2 no change before turnaround", int'(gates[1]), 0);
        end
        settle(20); window(40);
        check_leg(0, 64, 20, 3, 40, "R2 applied after turnaround");
    endtask

    task automatic t_no_dead();
        dead_cnt = 4'd0;
        set_ref(0, 32); set_ref(1, -16); set_ref(2, 0);
        settle(20); window(40);
        check_leg(0,  32, 20, 0, 40, "R7 zero dead time");
        check_leg(1, -16, 20, 0, 40, "R7 zero dead time");
    endtask

    initial begin
        rst_n = 1'b0;
        period = 8'd20;
        dead_cnt = 4'd3;
        ref_in = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_three_bands();
        t_edges();
        t_saturate();
        t_period();
        t_deferred();
        t_no_dead();
        check(overlaps == 0, "R7 pair overlap cycles", overlaps, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule